// File: doc/BRIEF.md
# Indirect Channel Access Port

This block is a byte-wide slave register port that lets a host processor reach a small per-channel memory through a window of four directly addressed registers. The host never addresses the memory itself. It loads a data buffer, then writes an address/control byte whose top bit picks the direction. That write launches an access that runs for a fixed number of clocks, and a busy flag stays up while it runs. When the flag drops, a read result is waiting in the data buffer.

The memory holds one byte per channel, with 128 entries at the default parameters, and it clears on reset. A configuration register holds an indirect-access enable and a per-channel enable. The indirect-access enable decides whether a write to the address/control register starts an access. The per-channel enable is only stored and read back. Host drivers poll the busy flag a bounded number of times, so every access must end well inside that window.

Top module: `ipa_port`

## Requirements
- R1: After reset, all four registers read 00h, busy is clear, and every memory entry reads back as 00h.
- R2: The configuration register at offset 0 stores bit 1 (indirect-access enable) and bit 0 (per-channel enable). Bits 7:2 always read 0.
- R3: When indirect access is enabled, a write to offset 2 while idle sets status bit 7 (busy) on the next clock. Busy stays set for exactly 4 cycles, so the status register reads 80h four times and then 00h.
- R4: A write to offset 2 with bit 7 = 0 stores the current data buffer (offset 3) into the memory entry given by bits 6:0.
- R5: A write to offset 2 with bit 7 = 1 reads the memory entry given by bits 6:0. When busy clears, that entry appears in the data buffer at offset 3.
- R6: While busy is set, host writes to offset 2 and offset 3 are ignored. No new access starts, and the address/control and data buffer values are kept.
- R7: When bit 1 of the configuration register is 0, a write to offset 2 starts no access. Busy stays clear and the memory is unchanged.
- R8: The status register at offset 1 is read-only. Bits 6:0 read 0, and a write to it has no effect.
- R9: Offset 2 reads back the last address/control byte the port accepted, including one written while indirect access was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_sel | input | 1 | Register access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_ofs | input | 2 | Register offset: 0 config, 1 status, 2 address/control, 3 data buffer |
| hst_wdata | input | 8 | Write data |
| hst_rdata | output | 8 | Read data for the offset on hst_ofs (combinational) |

## Verification
The bench builds the port with its default parameters: a 7-bit channel address, a byte data path, a 4-cycle access and memory cleared on reset. With these values the lowest entry (0) and the highest entry (127) are both reachable, and the exact 4-cycle busy window can be counted one cycle at a time. The busy window is also long enough to place two ignored host writes inside one access and observe that neither took effect.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

   typedef enum logic [1:0] {
      OFS_CFG  = 2'd0,
      OFS_STAT = 2'd1,
      OFS_ACTL = 2'd2,
      OFS_DATA = 2'd3
   } ipa_ofs_e;

   localparam int CFG_CHEN_BIT  = 0;
   localparam int CFG_INDEN_BIT = 1;
   localparam int CFG_BITS      = 2;

endpackage

// File: rtl/ipa_store.sv
module ipa_store #(
   parameter int ADDR_W         = 7,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_bus [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic              hit;
      logic [DATA_W-1:0] word_q;

      assign hit = we && (addr == ADDR_W'(i));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (hit) begin
               word_q <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) begin
               word_q <= wdata;
            end
         end
      end

      assign word_bus[i] = word_q;
   end

   assign rdata = word_bus[addr];

endmodule

// File: rtl/ipa_seq.sv
module ipa_seq #(
   parameter int ADDR_W      = 7,
   parameter int BUSY_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_rd,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic              acc_en,
   output logic              acc_rd,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam int RUN_W = CNT_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         addr_q <= '0;
      end else if (start) begin
         cnt_q  <= CNT_W'(BUSY_CYCLES);
         rd_q   <= start_rd;
         addr_q <= start_addr;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign busy     = (cnt_q != '0);
   assign acc_en   = (cnt_q == CNT_W'(1));
   assign acc_rd   = rd_q;
   assign acc_addr = addr_q;

   // Length of the current busy run, for the window check below
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (busy) begin
         run_q <= run_q + RUN_W'(1);
      end else begin
         run_q <= '0;
      end
   end

   // R3: every busy run lasts exactly BUSY_CYCLES clocks
   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RUN_W'(BUSY_CYCLES)));

   // R6: the register file never launches while an access runs
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/ipa_regs.sv
module ipa_regs
   import ipa_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hst_sel,
   input  logic                hst_we,
   input  logic [1:0]          hst_ofs,
   input  logic [DATA_W-1:0]   hst_wdata,
   output logic [DATA_W-1:0]   hst_rdata,
   input  logic                busy,
   input  logic                rd_load,
   input  logic [DATA_W-1:0]   rd_word,
   output logic [CFG_BITS-1:0] cfg,
   output logic                start,
   output logic                start_rd,
   output logic [ADDR_W-1:0]   start_addr,
   output logic [DATA_W-1:0]   dbuf
);

   localparam int DIR_BIT = DATA_W - 1;

   logic [CFG_BITS-1:0] cfg_q;
   logic [DATA_W-1:0]   actl_q;
   logic [DATA_W-1:0]   dbuf_q;
   logic                wr_cfg, wr_actl, wr_data;

   assign wr_cfg  = hst_sel && hst_we && (hst_ofs == OFS_CFG);
   assign wr_actl = hst_sel && hst_we && (hst_ofs == OFS_ACTL) && !busy;
   assign wr_data = hst_sel && hst_we && (hst_ofs == OFS_DATA) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         actl_q <= '0;
         dbuf_q <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_q <= hst_wdata[CFG_BITS-1:0];
         end
         if (wr_actl) begin
            actl_q <= hst_wdata;
         end
         if (rd_load) begin
            dbuf_q <= rd_word;
         end else if (wr_data) begin
            dbuf_q <= hst_wdata;
         end
      end
   end

   assign start      = wr_actl && cfg_q[CFG_INDEN_BIT];
   assign start_rd   = hst_wdata[DIR_BIT];
   assign start_addr = hst_wdata[ADDR_W-1:0];
   assign cfg        = cfg_q;
   assign dbuf       = dbuf_q;

   always_comb begin
      hst_rdata = '0;
      unique case (hst_ofs)
         OFS_CFG:  hst_rdata[CFG_BITS-1:0] = cfg_q;
         OFS_STAT: hst_rdata[DIR_BIT]      = busy;
         OFS_ACTL: hst_rdata               = actl_q;
         OFS_DATA: hst_rdata               = dbuf_q;
         default:  hst_rdata               = '0;
      endcase
   end

   // R6: the data buffer moves during an access only when a read completes
   p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_load) |=> $stable(dbuf_q));

   // R6: the address/control byte is frozen while an access is under way
   p_actl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_load) |=> $stable(actl_q));

endmodule

// File: rtl/ipa_port.sv
module ipa_port
   import ipa_pkg::*;
#(
   parameter int ADDR_W         = 7,
   parameter int DATA_W         = 8,
   parameter int BUSY_CYCLES    = 4,
   parameter int POLL_LIMIT     = 10,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_we,
   input  logic [1:0]        hst_ofs,
   input  logic [DATA_W-1:0] hst_wdata,
   output logic [DATA_W-1:0] hst_rdata
);

   if (ADDR_W < 1 || ADDR_W > DATA_W - 1) begin : g_bad_addr_w
      $error("ipa_port: ADDR_W must leave the top data bit free for the direction flag");
   end
   if (DATA_W < CFG_BITS + 1) begin : g_bad_data_w
      $error("ipa_port: DATA_W too narrow for the configuration fields");
   end
   if (BUSY_CYCLES < 1 || BUSY_CYCLES >= POLL_LIMIT) begin : g_bad_busy
      $error("ipa_port: BUSY_CYCLES must be at least 1 and below the host poll limit");
   end

   logic                busy, acc_en, acc_rd, start, start_rd;
   logic [ADDR_W-1:0]   acc_addr, start_addr;
   logic [DATA_W-1:0]   mem_rdata, dbuf;
   logic [CFG_BITS-1:0] cfg;

   ipa_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .hst_sel    (hst_sel),
      .hst_we     (hst_we),
      .hst_ofs    (hst_ofs),
      .hst_wdata  (hst_wdata),
      .hst_rdata  (hst_rdata),
      .busy       (busy),
      .rd_load    (acc_en && acc_rd),
      .rd_word    (mem_rdata),
      .cfg        (cfg),
      .start      (start),
      .start_rd   (start_rd),
      .start_addr (start_addr),
      .dbuf       (dbuf)
   );

   ipa_seq #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_rd   (start_rd),
      .start_addr (start_addr),
      .busy       (busy),
      .acc_en     (acc_en),
      .acc_rd     (acc_rd),
      .acc_addr   (acc_addr)
   );

   ipa_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_en && !acc_rd),
      .addr  (acc_addr),
      .wdata (dbuf),
      .rdata (mem_rdata)
   );

   // R3: an access begins only right after a host write to the address/control register
   p_host_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hst_sel && hst_we && (hst_ofs == OFS_ACTL)));

   // R7: with indirect access disabled, an address/control write leaves the port idle
   p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_sel && hst_we && (hst_ofs == OFS_ACTL) && !busy && !cfg[CFG_INDEN_BIT]) |=> !busy);

endmodule

// File: tb/tb_ipa_port.sv
module tb_ipa_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_sel = 1'b0;
   logic       hst_we = 1'b0;
   logic [1:0] hst_ofs = 2'd0;
   logic [7:0] hst_wdata = 8'h00;
   logic [7:0] hst_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ipa_port dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .hst_sel   (hst_sel),
      .hst_we    (hst_we),
      .hst_ofs   (hst_ofs),
      .hst_wdata (hst_wdata),
      .hst_rdata (hst_rdata)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic host_wr(input logic [1:0] ofs, input logic [7:0] data);
      hst_sel = 1'b1; hst_we = 1'b1; hst_ofs = ofs; hst_wdata = data;
      @(negedge clk);
      hst_sel = 1'b0; hst_we = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] ofs, output logic [7:0] data);
      hst_ofs = ofs;
      #1;
      data = hst_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int i = 0; i < 10; i++) begin
         host_rd(2'd1, st);
         if (st < 8'h80) break;
         @(negedge clk);
      end
   endtask

   task automatic ind_write(input logic [6:0] a, input logic [7:0] d);
      host_wr(2'd3, d);
      host_wr(2'd2, {1'b0, a});
      wait_idle();
   endtask

   task automatic ind_read(input logic [6:0] a, output logic [7:0] d);
      host_wr(2'd2, {1'b1, a});
      wait_idle();
      host_rd(2'd3, d);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int o = 0; o < 4; o++) begin
         host_rd(o[1:0], v);
         check("R1 register after reset", v, 8'h00);
      end
      host_wr(2'd0, 8'h02);
      ind_read(7'd0, v);
      check("R1 entry 0 after reset", v, 8'h00);
      ind_read(7'd127, v);
      check("R1 entry 127 after reset", v, 8'h00);
   endtask

   task automatic t_cfg();
      logic [7:0] v;
      host_wr(2'd0, 8'hFD);
      host_rd(2'd0, v);
      check("R2 config upper bits zero", v, 8'h01);
      host_wr(2'd0, 8'h03);
      host_rd(2'd0, v);
      check("R2 config both enables", v, 8'h03);
   endtask

   task automatic t_status_ro();
      logic [7:0] v;
      host_wr(2'd1, 8'hFF);
      host_rd(2'd1, v);
      check("R8 status write ignored", v, 8'h00);
   endtask

   task automatic t_busy_window();
      logic [7:0] v;
      host_wr(2'd3, 8'h5A);
      host_wr(2'd2, 8'h05);
      for (int c = 0; c < 4; c++) begin
         host_rd(2'd1, v);
         check("R3 busy during access", v, 8'h80);
         @(negedge clk);
      end
      host_rd(2'd1, v);
      check("R3 busy cleared after 4 cycles", v, 8'h00);
      ind_read(7'd5, v);
      check("R4 R5 entry 5 holds written byte", v, 8'h5A);
   endtask

   task automatic t_patterns();
      logic [7:0] v;
      ind_write(7'd0, 8'hC3);
      ind_write(7'd127, 8'h81);
      ind_write(7'd64, 8'hFF);
      ind_write(7'd10, 8'h3C);
      ind_read(7'd0, v);
      check("R5 entry 0", v, 8'hC3);
      ind_read(7'd127, v);
      check("R5 entry 127", v, 8'h81);
      ind_read(7'd64, v);
      check("R5 entry 64", v, 8'hFF);
      ind_read(7'd10, v);
      check("R4 entry 10", v, 8'h3C);
      host_rd(2'd2, v);
      check("R9 address/control readback", v, 8'h8A);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] v;
      host_wr(2'd3, 8'hA5);
      host_wr(2'd2, 8'h14);
      host_wr(2'd3, 8'h11);
      host_wr(2'd2, 8'h8A);
      @(negedge clk);
      @(negedge clk);
      host_rd(2'd1, v);
      check("R6 no second access started", v, 8'h00);
      host_rd(2'd2, v);
      check("R6 address/control kept", v, 8'h14);
      host_rd(2'd3, v);
      check("R6 data buffer kept", v, 8'hA5);
      ind_read(7'd20, v);
      check("R6 entry 20 from first access", v, 8'hA5);
      ind_read(7'd10, v);
      check("R6 entry 10 untouched", v, 8'h3C);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      host_wr(2'd0, 8'h01);
      host_wr(2'd3, 8'h77);
      host_wr(2'd2, 8'h05);
      host_rd(2'd1, v);
      check("R7 no busy when disabled", v, 8'h00);
      host_rd(2'd2, v);
      check("R9 address/control stored while disabled", v, 8'h05);
      host_wr(2'd0, 8'h02);
      ind_read(7'd5, v);
      check("R7 entry 5 unchanged", v, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      t_status_ro();
      t_busy_window();
      t_patterns();
      t_busy_ignore();
      t_disabled();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule